// File: doc/BRIEF.md
# PLL Settings Register with Write Interlocks

This block is a 32-bit control register that holds the settings for a clock synthesiser. It stores an input source select, an input predivider, a feedback multiplier, and three output post-dividers named P, Q and R. Each post-divider has its own output enable. Software writes the register through a simple single-cycle port with one strobe per byte lane. The current contents can always be read back on a read bus that is continuously driven.

Two live status inputs gate the writes, field by field. While the synthesiser is running, every ratio field and the source select are frozen. While the R output is the system clock, the R output enable is frozen. A write of the reserved R code 000 is refused. A blocked write attempt is reported by a one-cycle pulse. The block also decodes the R divider code into an integer ratio for downstream logic.

Top module: `pll_cfg_reg`

## Requirements
- R1: A synchronous active-high reset loads the register with 0x2204_0100. In that state the R ratio output is 2 and the R enable (bit 28) is 0.
- R2: Each byte lane k, covering bits 8k+7 down to 8k, is updated only when its strobe bit k is high in a write cycle. Lanes with a low strobe keep their value.
- R3: Bits 23:22, 15, 7, 3 and 2 always read as 0 whatever is written.
- R4: The ratio and source fields are frozen while `pll_on` is 1 at the write edge: R code 31:29, Q code 27:25, P code 21:17, N multiplier 14:8, M predivider 6:4 and source select 1:0 keep their value through any write.
- R5: The Q enable (bit 24) and P enable (bit 16) follow writes to their lane regardless of either status input.
- R6: The R enable (bit 28) ignores writes while `r_is_sysclk` is 1. Otherwise it follows writes, even while `pll_on` is 1.
- R7: A lane-3 write carrying R code 000 leaves the R code unchanged. The other fields in that lane are still handled by their own rules.
- R8: `r_ratio` always equals the stored R code plus one, giving 2 to 8 for codes 001 to 111.
- R9: `wr_blocked` is high for exactly the cycle after a write in which one of these holds: `pll_on` is 1 and any strobe is set; strobe 3 is set and `r_is_sysclk` is 1; or strobe 3 is set with R code 000. It is low otherwise.
- R10: `rd_data` shows the register contents, and a write appears on it in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write cycle qualifier |
| wr_strb | input | 4 | Per-byte-lane write strobes |
| wr_data | input | 32 | Write data |
| pll_on | input | 1 | Status: synthesiser running |
| r_is_sysclk | input | 1 | Status: R output drives the system clock |
| rd_data | output | 32 | Current register contents |
| r_ratio | output | 4 | Decoded R division ratio |
| wr_blocked | output | 1 | One-cycle pulse after a refused write |

## Verification
Several properties are checked on every cycle. Reserved bits stay zero, the ratio fields hold still while the synthesiser runs, and the R enable holds still while R is the system clock. The decoded R ratio stays within 2 to 8, and the blocked pulse follows the status-gated write conditions. Other behaviour can only be shown by the bench's scenarios: partial-lane writes that change one lane and leave its neighbours alone, the rejection of code 000 while other fields in that lane still update, and the enables of the P and Q outputs being written while the dividers are locked. The bench compares the read bus, the ratio and the pulse against a behavioural model on every clock.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int REG_W  = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = REG_W / LANE_W;

    localparam logic [REG_W-1:0] RSV_MASK = 32'h00C0_808C;
    localparam logic [REG_W-1:0] DIV_MASK = 32'hEE3E_7F73;

    typedef struct packed {
        logic [2:0] r_code;
        logic       r_en;
        logic [2:0] q_code;
        logic       q_en;
        logic [4:0] p_code;
        logic       p_en;
        logic [6:0] n_mult;
        logic [2:0] m_div;
        logic [1:0] src;
    } cfg_t;

    typedef struct packed {
        logic r_code;
        logic r_en;
        logic q_code;
        logic q_en;
        logic p_code;
        logic p_en;
        logic n_mult;
        logic m_div;
        logic src;
    } cfg_we_t;

    function automatic cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.r_code = w[31:29];
        c.r_en   = w[28];
        c.q_code = w[27:25];
        c.q_en   = w[24];
        c.p_code = w[21:17];
        c.p_en   = w[16];
        c.n_mult = w[14:8];
        c.m_div  = w[6:4];
        c.src    = w[1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input cfg_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[31:29] = c.r_code;
        w[28]    = c.r_en;
        w[27:25] = c.q_code;
        w[24]    = c.q_en;
        w[21:17] = c.p_code;
        w[16]    = c.p_en;
        w[14:8]  = c.n_mult;
        w[6:4]   = c.m_div;
        w[1:0]   = c.src;
        return w;
    endfunction

    function automatic logic [3:0] code_to_ratio(input logic [2:0] code);
        return {1'b0, code} + 4'd1;
    endfunction

endpackage

// File: rtl/pll_cfg_gate.sv
module pll_cfg_gate
    import pll_cfg_pkg::*;
(
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_strb,
    input  cfg_t             wr_cfg,
    input  logic             pll_on,
    input  logic             r_is_sysclk,
    output cfg_we_t          we,
    output logic             blocked
);
    logic [LANES-1:0] lane;
    logic             div_ok;
    logic             r_code_legal;

    always_comb begin
        lane         = wr_en ? wr_strb : '0;
        div_ok       = !pll_on;
        r_code_legal = (wr_cfg.r_code != 3'd0);

        we.r_code = lane[3] && div_ok && r_code_legal;
        we.r_en   = lane[3] && !r_is_sysclk;
        we.q_code = lane[3] && div_ok;
        we.q_en   = lane[3];
        we.p_code = lane[2] && div_ok;
        we.p_en   = lane[2];
        we.n_mult = lane[1] && div_ok;
        we.m_div  = lane[0] && div_ok;
        we.src    = lane[0] && div_ok;

        blocked = ((|lane) && pll_on)
                || (lane[3] && r_is_sysclk)
                || (lane[3] && !r_code_legal);
    end
endmodule

// File: rtl/pll_cfg_store.sv
module pll_cfg_store
    import pll_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = 32'h2204_0100
) (
    input  logic    clk,
    input  logic    rst,
    input  cfg_t    wr_cfg,
    input  cfg_we_t we,
    input  logic    blocked_in,
    output cfg_t    cfg,
    output logic    blocked_q
);
    localparam cfg_t RST_CFG = unpack_cfg(RESET_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= RST_CFG;
            blocked_q <= 1'b0;
        end else begin
            if (we.r_code) cfg.r_code <= wr_cfg.r_code;
            if (we.r_en)   cfg.r_en   <= wr_cfg.r_en;
            if (we.q_code) cfg.q_code <= wr_cfg.q_code;
            if (we.q_en)   cfg.q_en   <= wr_cfg.q_en;
            if (we.p_code) cfg.p_code <= wr_cfg.p_code;
            if (we.p_en)   cfg.p_en   <= wr_cfg.p_en;
            if (we.n_mult) cfg.n_mult <= wr_cfg.n_mult;
            if (we.m_div)  cfg.m_div  <= wr_cfg.m_div;
            if (we.src)    cfg.src    <= wr_cfg.src;
            blocked_q <= blocked_in;
        end
    end
endmodule

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode
    import pll_cfg_pkg::*;
(
    input  cfg_t             cfg,
    output logic [REG_W-1:0] rd_data,
    output logic [3:0]       r_ratio
);
    always_comb begin
        rd_data = pack_cfg(cfg);
        r_ratio = code_to_ratio(cfg.r_code);
    end
endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
    import pll_cfg_pkg::*;
#(
    parameter logic [31:0] RESET_VAL = 32'h2204_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_strb,
    input  logic [31:0] wr_data,
    input  logic        pll_on,
    input  logic        r_is_sysclk,
    output logic [31:0] rd_data,
    output logic [3:0]  r_ratio,
    output logic        wr_blocked
);
    cfg_t    wr_cfg;
    cfg_t    cfg;
    cfg_we_t we;
    logic    blocked;

    assign wr_cfg = unpack_cfg(wr_data);

    pll_cfg_gate u_gate (
        .wr_en       (wr_en),
        .wr_strb     (wr_strb),
        .wr_cfg      (wr_cfg),
        .pll_on      (pll_on),
        .r_is_sysclk (r_is_sysclk),
        .we          (we),
        .blocked     (blocked)
    );

    pll_cfg_store #(.RESET_VAL(RESET_VAL)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_cfg     (wr_cfg),
        .we         (we),
        .blocked_in (blocked),
        .cfg        (cfg),
        .blocked_q  (wr_blocked)
    );

    pll_cfg_decode u_decode (
        .cfg     (cfg),
        .rd_data (rd_data),
        .r_ratio (r_ratio)
    );
endmodule

// File: rtl/pll_cfg_reg_chk.sv
module pll_cfg_reg_chk
    import pll_cfg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [3:0]  wr_strb,
    input logic [31:0] wr_data,
    input logic        pll_on,
    input logic        r_is_sysclk,
    input logic [31:0] rd_data,
    input logic [3:0]  r_ratio,
    input logic        wr_blocked
);
    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == 32'h2204_0100));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & RSV_MASK) == 32'd0);

    // R4
    div_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        pll_on |=> $stable(rd_data & DIV_MASK));

    // R6
    r_en_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        r_is_sysclk |=> $stable(rd_data[28]));

    // R8
    r_ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
        (r_ratio >= 4'd2) && (r_ratio <= 4'd8));

    // R9
    blocked_on_run_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pll_on && (|wr_strb)) |=> wr_blocked);

    // R9
    no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_blocked);

    // R2
    lane0_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_strb[0]) |=> $stable(rd_data[7:0]));

    logic unused_in;
    assign unused_in = ^wr_data;
endmodule

bind pll_cfg_reg pll_cfg_reg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_strb     (wr_strb),
    .wr_data     (wr_data),
    .pll_on      (pll_on),
    .r_is_sysclk (r_is_sysclk),
    .rd_data     (rd_data),
    .r_ratio     (r_ratio),
    .wr_blocked  (wr_blocked)
);

// File: tb/pll_cfg_reg_test.sv
module pll_cfg_reg_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pll_on = 1'b0;
    logic        r_is_sysclk = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  r_ratio;
    logic        wr_blocked;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit armed = 1'b0;
    bit done = 1'b0;
    string tag = "R1";

    logic [31:0] mdl;
    logic        mblk;

    always #10 clk = ~clk;

    pll_cfg_reg uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_strb(wr_strb),
        .wr_data(wr_data), .pll_on(pll_on), .r_is_sysclk(r_is_sysclk),
        .rd_data(rd_data), .r_ratio(r_ratio), .wr_blocked(wr_blocked)
    );

    // behavioural reference model, bit by bit from the requirements
    always @(posedge clk) begin
        if (rst) begin
            mdl   <= 32'h2204_0100;
            mblk  <= 1'b0;
            armed <= 1'b1;
        end else begin
            logic [31:0] nxt;
            bit          blk;
            nxt = mdl;
            blk = 1'b0;
            if (wr_en) begin
                for (int i = 0; i < 32; i++) begin
                    bit reserved, frozen;
                    if (!wr_strb[i/8]) continue;
                    reserved = (i == 23 || i == 22 || i == 15 || i == 7 || i == 3 || i == 2);
                    if (reserved) continue;
                    frozen = 1'b0;
                    if (i == 28) frozen = r_is_sysclk;
                    else if (i != 24 && i != 16) frozen = pll_on;
                    if (i >= 29 && wr_data[31:29] == 3'd0) frozen = 1'b1;
                    if (frozen) blk = 1'b1;
                    else nxt[i] = wr_data[i];
                end
                if (pll_on && wr_strb != 4'd0) blk = 1'b1;
            end
            mdl  <= nxt;
            mblk <= blk;
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", t, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (armed && !rst && !done) begin
            chk(tag, rd_data, mdl);
            chk("R3", rd_data & 32'h00C0_808C, 32'd0);
            chk("R8", {28'd0, r_ratio}, {28'd0, 1'b0, mdl[31:29]} + 32'd1);
            chk("R9", {31'd0, wr_blocked}, {31'd0, mblk});
        end
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = 4'd0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        tag = "R1";
        idle(2);
        chk("R1", rd_data, 32'h2204_0100);
        chk("R1", {28'd0, r_ratio}, 32'd2);

        tag = "R10";
        wr(4'hF, 32'hFFFF_FFFF);
        chk("R10", rd_data, 32'hFF3F_7F73);

        tag = "R2";
        wr(4'h1, 32'h0000_0020);
        wr(4'h2, 32'h0000_1500);
        wr(4'h4, 32'h0005_0000);
        wr(4'h8, 32'h6100_0000);
        wr(4'h3, 32'h1234_5641);
        idle(2);

        tag = "R4";
        pll_on = 1'b1;
        wr(4'hF, 32'h0000_0000);
        wr(4'h2, 32'h0000_7F00);
        wr(4'h1, 32'h0000_0033);
        idle(2);

        tag = "R5";
        wr(4'h4, 32'h0001_0000);
        wr(4'h8, 32'h0100_0000);
        wr(4'h8, 32'h0000_0000);

        tag = "R6";
        wr(4'h8, 32'h1000_0000);
        r_is_sysclk = 1'b1;
        wr(4'h8, 32'h0000_0000);
        pll_on = 1'b0;
        wr(4'h8, 32'hE000_0000);
        r_is_sysclk = 1'b0;
        wr(4'h8, 32'h0000_0000);

        tag = "R7";
        wr(4'h8, 32'h1300_0000);
        wr(4'hF, 32'h0000_0000);

        tag = "R8";
        for (int c = 1; c < 8; c++) wr(4'h8, {c[2:0], 29'd0});

        tag = "R9";
        idle(3);
        wr(4'h0, 32'hFFFF_FFFF);
        pll_on = 1'b1;
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h1, 32'h0000_0001);
        pll_on = 1'b0;

        tag = "R1";
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        chk("R1", rd_data, 32'h2204_0100);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule